// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches eight input pins and turns their activity into interrupt requests. Two configuration registers set the trigger for each pin. One picks level or edge sensitivity. The other picks the active sense: low level or falling edge, or high level or rising edge. Every pin input passes through a two-flop synchronizer. An optional per-pin debounce filter can follow it, and it accepts a new level only after the level has held for a fixed number of sample ticks.

Edge events are latched until software clears them by writing a per-pin mask to a clear register. A level-triggered pin reports its live filtered level. A raw status register shows every pending pin. A masked status register shows raw status ANDed with the enable register, and a single interrupt output is high whenever any masked bit is set. The block has no both-edges mode. Software gets that behaviour by flipping a pin's polarity bit after each event it services.

Register access uses a simple byte-wide bus. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, all configuration registers read 0 and `irqOut` is low. With all pins low, raw status reads 0xFF, because every pin defaults to active-low level.
- R2: Offsets 0x00 (edge select, 1 = edge), 0x04 (polarity, 1 = high/rising), 0x0C (enable) and 0x18 (debounce enable) read back the last byte written. Bit n of each register belongs to pin n.
- R3: For a pin with edge select 0, raw status bit n equals the filtered pin level when polarity is 1, and its inverse when polarity is 0. Without debounce, a pin change shows three clock edges after it is applied.
- R4: For a pin with edge select 1, a transition of the filtered level in the chosen direction sets raw bit n one edge later, and the bit stays set after the input returns.
- R5: Writing a mask to offset 0x08 clears the latched edge of each pin whose mask bit is 1, and leaves the others unchanged. A new edge detected in the same cycle wins over the clear. Offset 0x08 reads 0.
- R6: A clear write has no effect on the raw bit of a level-sensitive pin.
- R7: Offset 0x10 reads raw status AND enable, and `irqOut` is high exactly when that value is nonzero.
- R8: Edges are latched while the pin is disabled, so enabling the pin afterwards raises `irqOut` at once.
- R9: Writing edge select or polarity does not by itself latch an edge. While a pin is level-sensitive its edge latch is held clear.
- R10: With debounce enabled for a pin, a new level is accepted only after it differs from the accepted level on DEB_TICKS consecutive sample ticks. A sample tick comes once every TICK_DIV clocks. Shorter glitches are rejected.
- R11: Writes to offsets 0x10 and 0x14 change nothing. Unmapped offsets read 0.
- R12: Flipping a pin's polarity after each serviced edge catches both the rising and the falling transitions of that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| pinIn | input | 8 | Asynchronous pin inputs |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A clear written in the same cycle that a new edge arrives must not lose the new edge. A design where the clear wins would drop that interrupt without a trace. Clear writes aimed at level pins must leave their status alone, and a design that stored level pins in the latch would show them vanishing until the next sample. Polarity writes on a stable pin must not produce a phantom event, a fault that shows up as a false interrupt when software emulates both edges. The debounce glitch test catches a filter that counts non-consecutive ticks or accepts early, because either one passes the short pulse through to raw status.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  parameter int unsigned PIN_COUNT = 8;
  localparam int unsigned ADDR_W = 5;

  typedef logic [PIN_COUNT-1:0] pinVec_t;

  localparam logic [ADDR_W-1:0] OFF_EDGE  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_POL   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_EN    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_RSTAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_DEB   = 5'h18;

  // control-to-datapath bundle
  typedef struct packed {
    pinVec_t edgeSel;
    pinVec_t polHigh;
    pinVec_t enable;
    pinVec_t debEn;
    pinVec_t clrMask;   // one-cycle strobe
  } ctlBus_t;
endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  pinVec_t           busWrData,
  input  pinVec_t           rawPend,
  input  pinVec_t           maskPend,
  output ctlBus_t           ctl,
  output pinVec_t           busRdData
);
  pinVec_t edgeReg, polReg, enReg, debReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edgeReg <= '0;
      polReg  <= '0;
      enReg   <= '0;
      debReg  <= '0;
    end else if (busWrEn) begin
      unique case (busAddr)
        OFF_EDGE: edgeReg <= busWrData;
        OFF_POL:  polReg  <= busWrData;
        OFF_EN:   enReg   <= busWrData;
        OFF_DEB:  debReg  <= busWrData;
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctl.edgeSel = edgeReg;
    ctl.polHigh = polReg;
    ctl.enable  = enReg;
    ctl.debEn   = debReg;
    ctl.clrMask = (busWrEn && busAddr == OFF_CLR) ? busWrData : '0;
  end

  always_comb begin
    unique case (busAddr)
      OFF_EDGE:  busRdData = edgeReg;
      OFF_POL:   busRdData = polReg;
      OFF_EN:    busRdData = enReg;
      OFF_DEB:   busRdData = debReg;
      OFF_MSTAT: busRdData = maskPend;
      OFF_RSTAT: busRdData = rawPend;
      default:   busRdData = '0;
    endcase
  end

  // R11: status offsets are read-only
  a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && (busAddr == OFF_MSTAT || busAddr == OFF_RSTAT))
      |=> ($stable(edgeReg) && $stable(polReg) && $stable(enReg) && $stable(debReg)));
endmodule

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
  parameter int unsigned DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic syncLvl,
  input  logic debEn,
  input  logic tick,
  output logic filtLvl
);
  localparam int unsigned CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filtLvl <= 1'b0;
      runCnt  <= '0;
    end else if (!debEn) begin
      filtLvl <= syncLvl;
      runCnt  <= '0;
    end else if (tick) begin
      if (syncLvl == filtLvl) begin
        runCnt <= '0;
      end else if (runCnt == LAST) begin
        filtLvl <= syncLvl;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R10: a debounced level only moves on a sample tick
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (debEn && !tick) |=> $stable(filtLvl));
endmodule

// File: rtl/pin_irq_path.sv
module pin_irq_path
  import pin_irq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 8,
  parameter int unsigned DEB_TICKS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pinVec_t pinIn,
  input  ctlBus_t ctl,
  output pinVec_t rawPend,
  output pinVec_t maskPend,
  output logic    irqAny
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

  pinVec_t syncQ [SYNC_STAGES];
  pinVec_t filt, hist, edgeLatch, detect;
  logic [TW-1:0] tickCnt;
  logic tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tickCnt <= '0;
    else if (tick)   tickCnt <= '0;
    else             tickCnt <= tickCnt + 1'b1;
  end
  assign tick = (tickCnt == TICK_LAST);

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    pin_irq_filter #(.DEB_TICKS(DEB_TICKS)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .syncLvl (syncQ[SYNC_STAGES-1][p]),
      .debEn   (ctl.debEn[p]),
      .tick    (tick),
      .filtLvl (filt[p])
    );
  end

  assign detect = ctl.edgeSel & ((ctl.polHigh & filt & ~hist) |
                                 (~ctl.polHigh & ~filt & hist));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist      <= '0;
      edgeLatch <= '0;
    end else begin
      hist      <= filt;
      edgeLatch <= ctl.edgeSel & (detect | (edgeLatch & ~ctl.clrMask));
    end
  end

  assign rawPend  = (ctl.edgeSel & edgeLatch) | (~ctl.edgeSel & ~(ctl.polHigh ^ filt));
  assign maskPend = rawPend & ctl.enable;
  assign irqAny   = |maskPend;

  // R5: a cleared bit stays clear unless a fresh edge arrived
  a_r5_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl.clrMask) |=> ((edgeLatch & $past(ctl.clrMask) & ~$past(detect)) == '0));
  // R9: level-sensitive pins never hold a latched edge
  a_r9_level_latch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edgeLatch & ~$past(ctl.edgeSel)) == '0));
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
  parameter int unsigned TICK_DIV  = 8,
  parameter int unsigned DEB_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [7:0] pinIn,
  output logic       irqOut
);
  import pin_irq_pkg::*;

  ctlBus_t ctl;
  pinVec_t rawPend, maskPend;

  pin_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .rawPend   (rawPend),
    .maskPend  (maskPend),
    .ctl       (ctl),
    .busRdData (busRdData)
  );

  pin_irq_path #(.TICK_DIV(TICK_DIV), .DEB_TICKS(DEB_TICKS)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .ctl      (ctl),
    .rawPend  (rawPend),
    .maskPend (maskPend),
    .irqAny   (irqOut)
  );

  // R7: no request without some enabled pin
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (|ctl.enable));
endmodule

// File: tb/pin_irq_unit_test.sv
`timescale 1ns/1ps
module pin_irq_unit_test;
  localparam int TICK_DIV = 8;
  localparam int DEB_TICKS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] busAddr = 5'h00;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] pinIn = 8'h00;
  logic irqOut;

  int errors = 0;
  int checks = 0;
  bit cmpOn = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_irq_unit #(.TICK_DIV(TICK_DIV), .DEB_TICKS(DEB_TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .irqOut(irqOut));

  // behavioural reference
  int mS1[8], mS2[8], mFilt[8], mHist[8], mRun[8], mLat[8];
  int mTick;
  logic [7:0] mEdge, mPol, mEn, mDeb;

  function automatic logic [7:0] modelRaw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = mEdge[i] ? (mLat[i] != 0) : (mPol[i] ? (mFilt[i] != 0) : (mFilt[i] == 0));
    return r;
  endfunction

  function automatic logic [7:0] modelRead(input logic [4:0] a);
    case (a)
      5'h00: return mEdge;
      5'h04: return mPol;
      5'h0C: return mEn;
      5'h10: return modelRaw() & mEn;
      5'h14: return modelRaw();
      5'h18: return mDeb;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mS1[i] = 0; mS2[i] = 0; mFilt[i] = 0; mHist[i] = 0; mRun[i] = 0; mLat[i] = 0;
      end
      mTick = 0; mEdge = 0; mPol = 0; mEn = 0; mDeb = 0;
    end else begin
      bit tk;
      tk = (mTick == TICK_DIV - 1);
      for (int i = 0; i < 8; i++) begin
        bit hit, clr;
        hit = mEdge[i] && (mPol[i] ? (mFilt[i] == 1 && mHist[i] == 0)
                                   : (mFilt[i] == 0 && mHist[i] == 1));
        clr = busWrEn && busAddr == 5'h08 && busWrData[i];
        mLat[i] = (mEdge[i] && (hit || (mLat[i] != 0 && !clr))) ? 1 : 0;
        mHist[i] = mFilt[i];
        if (!mDeb[i]) begin
          mFilt[i] = mS2[i]; mRun[i] = 0;
        end else if (tk) begin
          if (mS2[i] == mFilt[i]) mRun[i] = 0;
          else if (mRun[i] == DEB_TICKS - 1) begin mFilt[i] = mS2[i]; mRun[i] = 0; end
          else mRun[i]++;
        end
        mS2[i] = mS1[i];
        mS1[i] = pinIn[i];
      end
      mTick = tk ? 0 : mTick + 1;
      if (busWrEn) case (busAddr)
        5'h00: mEdge = busWrData;
        5'h04: mPol = busWrData;
        5'h0C: mEn = busWrData;
        5'h18: mDeb = busWrData;
        default: ;
      endcase
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input logic [4:0] a);
    case (a)
      5'h00, 5'h04, 5'h0C, 5'h18: return "R2 config readback";
      5'h08: return "R5 clear offset reads zero";
      5'h10: return "R7 masked status";
      5'h14: return "R4 raw status";
      default: return "R11 unmapped offset";
    endcase
  endfunction

  // compared every cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && cmpOn && !done) begin
      check({7'd0, irqOut}, {7'd0, |(modelRaw() & mEn)}, "R7 irq line");
      check(busRdData, modelRead(busAddr), tagOf(busAddr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask
  task automatic look(input logic [4:0] a, input string tag);
    @(negedge clk); busAddr = a; #2;
    check(busRdData, modelRead(a), tag);
  endtask
  task automatic lookVal(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); busAddr = a; #2;
    check(busRdData, exp, tag);
  endtask
  task automatic drive(input logic [7:0] v);
    @(negedge clk); pinIn = v;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    cmpOn = 1;
    // R1 reset state
    idle(4);
    lookVal(5'h14, 8'hFF, "R1 raw after reset");
    lookVal(5'h00, 8'h00, "R1 edge reg after reset");
    lookVal(5'h0C, 8'h00, "R1 enable after reset");
    lookVal(5'h10, 8'h00, "R1 masked after reset");
    check({7'd0, irqOut}, 8'h00, "R1 irq after reset");

    // R2 configuration: pins 0..3 edge, pins 0,2 rising, pin5 level-high
    wr(5'h00, 8'h0F); lookVal(5'h00, 8'h0F, "R2 edge select");
    wr(5'h04, 8'h25); lookVal(5'h04, 8'h25, "R2 polarity");
    lookVal(5'h08, 8'h00, "R5 clear offset reads zero");

    // R3 level pins follow input
    drive(8'h30); idle(4);
    look(5'h14, "R3 level pins track input");
    drive(8'h00); idle(4);
    look(5'h14, "R3 level pins after release");

    // R4, R8 edges latched while disabled
    drive(8'h03); idle(5);
    drive(8'h01); idle(5);
    look(5'h14, "R4 rise pin0 and fall pin1 latched");
    drive(8'h00); idle(5);
    look(5'h14, "R4 latch holds after input returns");
    check({7'd0, irqOut}, 8'h00, "R8 no irq while disabled");
    wr(5'h0C, 8'hFF);
    check({7'd0, irqOut}, 8'h01, "R8 irq after enabling");
    look(5'h10, "R7 masked after enable");

    // R5 per-pin clear, R6 level pins ignore clear
    wr(5'h08, 8'h01);
    look(5'h14, "R5 pin0 cleared, pin1 kept");
    wr(5'h08, 8'hF0);
    look(5'h14, "R6 level pins unaffected by clear");
    wr(5'h08, 8'h0F);

    // R5 clear in same cycle as new edge: edge wins
    drive(8'h01); idle(2);
    @(negedge clk); busAddr = 5'h08; busWrData = 8'h01; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    look(5'h14, "R5 simultaneous edge survives clear");
    drive(8'h00); wr(5'h08, 8'hFF); idle(4);

    // R9 polarity/mode writes make no event
    wr(5'h04, 8'h21); idle(3);
    look(5'h14, "R9 polarity flip no event");
    wr(5'h00, 8'h0E); idle(2);
    wr(5'h00, 8'h0F); idle(3);
    look(5'h14, "R9 mode toggle clears latch no event");

    // R12 both-edge emulation on pin3
    wr(5'h04, 8'h29);
    drive(8'h08); idle(5);
    look(5'h14, "R12 rising caught");
    wr(5'h08, 8'h08); wr(5'h04, 8'h21);
    look(5'h14, "R12 flip no event");
    drive(8'h00); idle(5);
    look(5'h14, "R12 falling caught");
    wr(5'h08, 8'h08);

    // R10 debounce on pin7, level-high
    wr(5'h04, 8'hA1); wr(5'h18, 8'h80); idle(4);
    look(5'h14, "R10 baseline");
    drive(8'h80); idle(10); drive(8'h00);
    idle(TICK_DIV * DEB_TICKS * 2);
    look(5'h14, "R10 glitch rejected");
    drive(8'h80); idle(TICK_DIV * (DEB_TICKS + 2));
    look(5'h14, "R10 stable level accepted");
    drive(8'h00); idle(TICK_DIV * (DEB_TICKS + 2));

    // R11 read-only and unmapped offsets
    wr(5'h10, 8'hFF); wr(5'h14, 8'hFF);
    lookVal(5'h00, 8'h0F, "R11 edge select untouched");
    lookVal(5'h0C, 8'hFF, "R11 enable untouched");
    lookVal(5'h1C, 8'h00, "R11 unmapped offset");
    look(5'h10, "R7 masked final");
    idle(4);
    finishRun();
  end
endmodule